// File: doc/BRIEF.md
# Dual-Direction AES Byte Substitution Unit

This block performs byte substitution for both directions of the AES cipher with one shared datapath. A mode bit, sampled with each byte, chooses between the forward substitution used when encrypting and the inverse substitution used when decrypting. The two directions share one multiplicative-inversion core.

The core inverts in GF(2^8) without any table. It maps the byte into a composite field GF((2^4)^2), inverts it there with GF(2^4) multiply, square and inverse sub-blocks, and maps the result back. In forward mode the input goes straight into the core and the AES affine transform is applied at the output. In inverse mode the inverse affine transform is applied at the input and the core output is the result. The linear mappings between the AES field and the tower field are derived when the design is elaborated, from the field polynomials. No matrix is written out by hand.

The inversion logic is purely combinational. Registers can therefore be placed around it or inside it. A parameter chooses whether one output register stage with a valid flag is present.

Top module: `sbox_dual`

## Requirements
- R1: With `in_inv` = 0, `out_byte` equals the AES forward substitution of `in_byte`: the GF(2^8) inverse under x^8+x^4+x^3+x+1 (zero maps to zero), followed by the affine step in which output bit i = a[i]^a[i+4]^a[i+5]^a[i+6]^a[i+7]^c[i], with indices taken mod 8 and c = 0x63.
- R2: With `in_inv` = 1, `out_byte` equals the AES inverse substitution of `in_byte`. This is the inverse affine step (bit i = b[i+2]^b[i+5]^b[i+7]^d[i], with d = 0x05), followed by the same GF(2^8) inverse.
- R3: For every byte x, feeding the forward result of x back in with `in_inv` = 1 returns x.
- R4: The zero element passes through the inverter as zero. Forward 0x00 gives 0x63, inverse 0x63 gives 0x00, and inverse 0x00 gives 0x52.
- R5: With PIPE_STAGE = 1, a byte presented with `in_valid` high appears on `out_byte` after the next rising clock edge, and `out_valid` equals `in_valid` delayed by one cycle.
- R6: With PIPE_STAGE = 1, a cycle with `in_valid` low leaves `out_byte` unchanged and drives `out_valid` low.
- R7: With PIPE_STAGE = 1, synchronous active-high `rst` clears `out_valid` and `out_byte` to 0.
- R8: With PIPE_STAGE = 0, `out_byte` and `out_valid` follow the inputs in the same cycle, with `out_valid` = `in_valid`.
- R9: The mode is taken per byte, so back-to-back bytes with alternating `in_inv` each receive their own direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used only when PIPE_STAGE = 1) |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte qualifier |
| in_inv | input | 1 | 0 = forward substitution, 1 = inverse substitution |
| in_byte | input | 8 | Byte to substitute |
| out_valid | output | 1 | Output byte qualifier |
| out_byte | output | 8 | Substituted byte |

## Verification
The bench builds two copies of the block side by side. One uses PIPE_STAGE = 1, which brings the register stage, its reset, its hold-when-idle behaviour and the one-cycle valid delay within reach. The other uses PIPE_STAGE = 0, which exposes the combinational path in the same cycle. Both copies receive the same stimulus. Every one of the 256 bytes is compared in both modes against a field-arithmetic model held in the bench. The forward-then-inverse round trip, the zero corner case and alternating-mode streams are checked on both copies.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int MAT_W  = BYTE_W * BYTE_W;

  localparam logic [BYTE_W-1:0] FWD_CONST = 8'h63;
  localparam logic [BYTE_W-1:0] INV_CONST = 8'h05;
  // AES reduction polynomial without its x^8 term
  localparam logic [BYTE_W-1:0] AES_POLY_LO = 8'h1B;

  // GF(2^4) multiply, polynomial basis, x^4 + x + 1
  function automatic logic [NIB_W-1:0] gf16_mul(input logic [NIB_W-1:0] a,
                                                input logic [NIB_W-1:0] b);
    logic [NIB_W-1:0] acc;
    logic [NIB_W-1:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < NIB_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[NIB_W-2:0], 1'b0} ^ (sh[NIB_W-1] ? 4'h3 : 4'h0);
    end
    return acc;
  endfunction

  function automatic logic [NIB_W-1:0] gf16_sq(input logic [NIB_W-1:0] a);
    return gf16_mul(a, a);
  endfunction

  // Smallest lambda for which y^2 + y + lambda has no root in GF(2^4)
  function automatic logic [NIB_W-1:0] pick_lambda();
    logic [NIB_W-1:0] lam;
    logic hit;
    logic done;
    lam  = 4'h1;
    done = 1'b0;
    for (int c = 1; c < 16; c++) begin
      hit = 1'b0;
      for (int t = 0; t < 16; t++)
        if ((gf16_sq(4'(t)) ^ 4'(t)) == 4'(c)) hit = 1'b1;
      if (!hit && !done) begin
        lam  = 4'(c);
        done = 1'b1;
      end
    end
    return lam;
  endfunction

  localparam logic [NIB_W-1:0] LAMBDA = pick_lambda();

  // GF((2^4)^2) multiply, element = {hi, lo} meaning hi*y + lo
  function automatic logic [BYTE_W-1:0] tower_mul(input logic [BYTE_W-1:0] a,
                                                  input logic [BYTE_W-1:0] b);
    logic [NIB_W-1:0] hh;
    logic [NIB_W-1:0] hi;
    logic [NIB_W-1:0] lo;
    hh = gf16_mul(a[7:4], b[7:4]);
    hi = hh ^ gf16_mul(a[7:4], b[3:0]) ^ gf16_mul(a[3:0], b[7:4]);
    lo = gf16_mul(a[3:0], b[3:0]) ^ gf16_mul(hh, LAMBDA);
    return {hi, lo};
  endfunction

  // A root of the AES polynomial inside the tower field
  function automatic logic [BYTE_W-1:0] pick_root();
    logic [BYTE_W-1:0] g;
    logic [BYTE_W-1:0] r;
    logic done;
    g    = 8'h02;
    done = 1'b0;
    for (int c = 2; c < 256 && !done; c++) begin
      r = 8'h01;
      for (int k = BYTE_W - 1; k >= 0; k--)
        r = tower_mul(r, 8'(c)) ^ (AES_POLY_LO[k] ? 8'h01 : 8'h00);
      if (r == 8'h00) begin
        g    = 8'(c);
        done = 1'b1;
      end
    end
    return g;
  endfunction

  localparam logic [BYTE_W-1:0] ROOT = pick_root();

  function automatic logic [BYTE_W-1:0] mat_apply(input logic [MAT_W-1:0] m,
                                                  input logic [BYTE_W-1:0] x);
    logic [BYTE_W-1:0] r;
    r = '0;
    for (int i = 0; i < BYTE_W; i++)
      if (x[i]) r = r ^ m[BYTE_W*i +: BYTE_W];
    return r;
  endfunction

  // Column i is ROOT^i: AES polynomial basis into the tower field
  function automatic logic [MAT_W-1:0] build_to_tower();
    logic [MAT_W-1:0] m;
    logic [BYTE_W-1:0] p;
    m = '0;
    p = 8'h01;
    for (int i = 0; i < BYTE_W; i++) begin
      m[BYTE_W*i +: BYTE_W] = p;
      p = tower_mul(p, ROOT);
    end
    return m;
  endfunction

  localparam logic [MAT_W-1:0] TO_TOWER = build_to_tower();

  // Inverse map: column j is the AES byte that lands on unit vector j
  function automatic logic [MAT_W-1:0] build_from_tower();
    logic [MAT_W-1:0] m;
    logic [BYTE_W-1:0] y;
    m = '0;
    for (int a = 0; a < 256; a++) begin
      y = mat_apply(TO_TOWER, 8'(a));
      for (int j = 0; j < BYTE_W; j++)
        if (y == (8'h01 << j)) m[BYTE_W*j +: BYTE_W] = 8'(a);
    end
    return m;
  endfunction

  localparam logic [MAT_W-1:0] FROM_TOWER = build_from_tower();

  function automatic logic [BYTE_W-1:0] affine_fwd(input logic [BYTE_W-1:0] a);
    logic [BYTE_W-1:0] b;
    for (int i = 0; i < BYTE_W; i++)
      b[i] = a[i] ^ a[(i+4)%8] ^ a[(i+5)%8] ^ a[(i+6)%8] ^ a[(i+7)%8] ^ FWD_CONST[i];
    return b;
  endfunction

  function automatic logic [BYTE_W-1:0] affine_inv(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] a;
    for (int i = 0; i < BYTE_W; i++)
      a[i] = b[(i+2)%8] ^ b[(i+5)%8] ^ b[(i+7)%8] ^ INV_CONST[i];
    return a;
  endfunction

endpackage

// File: rtl/sbox_gf16_inv.sv
module sbox_gf16_inv
  import sbox_pkg::*;
(
  input  logic [NIB_W-1:0] a,
  output logic [NIB_W-1:0] a_inv
);
  // a^14 = a^2 * a^4 * a^8; zero stays zero
  logic [NIB_W-1:0] p2, p4, p8;

  always_comb begin
    p2    = gf16_sq(a);
    p4    = gf16_sq(p2);
    p8    = gf16_sq(p4);
    a_inv = gf16_mul(gf16_mul(p2, p4), p8);
  end
endmodule

// File: rtl/sbox_tower_inv.sv
module sbox_tower_inv
  import sbox_pkg::*;
(
  input  logic [BYTE_W-1:0] t_in,
  output logic [BYTE_W-1:0] t_out
);
  logic [NIB_W-1:0] hi, lo, delta, delta_inv;

  assign hi = t_in[BYTE_W-1:NIB_W];
  assign lo = t_in[NIB_W-1:0];

  // norm: hi^2*lambda + hi*lo + lo^2
  always_comb
    delta = gf16_mul(gf16_sq(hi), LAMBDA) ^ gf16_mul(hi, lo) ^ gf16_sq(lo);

  sbox_gf16_inv u_sub_inv (
    .a     (delta),
    .a_inv (delta_inv)
  );

  always_comb
    t_out = {gf16_mul(hi, delta_inv), gf16_mul(hi ^ lo, delta_inv)};
endmodule

// File: rtl/sbox_lin_map.sv
module sbox_lin_map
  import sbox_pkg::*;
#(
  parameter logic [MAT_W-1:0] MAT = '0
) (
  input  logic [BYTE_W-1:0] x,
  output logic [BYTE_W-1:0] y
);
  always_comb y = mat_apply(MAT, x);
endmodule

// File: rtl/sbox_dual.sv
module sbox_dual
  import sbox_pkg::*;
#(
  parameter int PIPE_STAGE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_inv,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte
);
  logic [BYTE_W-1:0] core_in, tower_in, tower_out, core_out, result;

  // inverse direction strips the affine step before the shared inversion
  assign core_in = in_inv ? affine_inv(in_byte) : in_byte;

  sbox_lin_map #(.MAT(TO_TOWER)) u_to_tower (
    .x (core_in),
    .y (tower_in)
  );

  sbox_tower_inv u_inv (
    .t_in  (tower_in),
    .t_out (tower_out)
  );

  sbox_lin_map #(.MAT(FROM_TOWER)) u_from_tower (
    .x (tower_out),
    .y (core_out)
  );

  assign result = in_inv ? core_out : affine_fwd(core_out);

  generate
    if (PIPE_STAGE != 0) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          out_valid <= 1'b0;
          out_byte  <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) out_byte <= result;
        end
      end
    end else begin : g_comb
      assign out_valid = in_valid;
      assign out_byte  = result;
    end
  endgenerate
endmodule

// File: rtl/sbox_dual_chk.sv
module sbox_dual_chk #(
  parameter int PIPE_STAGE = 1
) (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_inv,
  input logic [7:0] in_byte,
  input logic       out_valid,
  input logic [7:0] out_byte
);
  generate
    if (PIPE_STAGE != 0) begin : g_reg
      p_zero_fwd_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_inv && in_byte == 8'h00) |=> (out_byte == 8'h63));
      p_zero_inv_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_inv && in_byte == 8'h00) |=> (out_byte == 8'h52));
      p_valid_delay_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
      p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_byte)));
      p_reset_clear_r7: assert property (@(posedge clk)
        rst |=> (!out_valid && out_byte == 8'h00));
    end else begin : g_comb
      p_zero_fwd_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_inv && in_byte == 8'h00) |-> (out_byte == 8'h63));
      p_zero_inv_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_inv && in_byte == 8'h63) |-> (out_byte == 8'h00));
      p_same_cycle_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid == in_valid);
    end
  endgenerate
endmodule

bind sbox_dual sbox_dual_chk #(.PIPE_STAGE(PIPE_STAGE)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_inv    (in_inv),
  .in_byte   (in_byte),
  .out_valid (out_valid),
  .out_byte  (out_byte)
);

// File: tb/sbox_dual_tb.sv
module sbox_dual_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_inv = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic ov_r, ov_c;
  logic [7:0] ob_r, ob_c;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] fwd_ref [256];
  logic [7:0] inv_ref [256];

  always #5 clk = ~clk;

  sbox_dual #(.PIPE_STAGE(1)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_inv(in_inv),
    .in_byte(in_byte), .out_valid(ov_r), .out_byte(ob_r));

  sbox_dual #(.PIPE_STAGE(0)) u_dut_comb (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_inv(in_inv),
    .in_byte(in_byte), .out_valid(ov_c), .out_byte(ob_c));

  // {mode, input, expected}
  localparam logic [16:0] VECS [10] = '{
    {1'b0, 8'h00, 8'h63}, {1'b0, 8'h01, 8'h7C}, {1'b0, 8'h53, 8'hED},
    {1'b0, 8'hFF, 8'h16}, {1'b0, 8'h10, 8'hCA}, {1'b0, 8'h80, 8'hCD},
    {1'b1, 8'h63, 8'h00}, {1'b1, 8'h00, 8'h52}, {1'b1, 8'hED, 8'h53},
    {1'b1, 8'h16, 8'hFF}
  };

  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1B : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [7:0] ref_inv(input logic [7:0] a);
    logic [7:0] r = 8'h01;
    logic [7:0] base = a;
    for (int e = 0; e < 8; e++) begin
      if (e != 0) r = ref_mul(r, base);
      base = ref_mul(base, base);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // one input cycle: combinational copy checked mid-cycle, registered copy after the edge
  task automatic step(input logic v, input logic m, input logic [7:0] b,
                      input logic [7:0] exp, input string tag);
    @(negedge clk);
    in_valid = v; in_inv = m; in_byte = b;
    #1;
    check({7'd0, ov_c}, {7'd0, v}, "R8 comb valid");
    if (v) check(ob_c, exp, tag);
    @(posedge clk); #1;
    check({7'd0, ov_r}, {7'd0, v}, "R5 reg valid");
    if (v) check(ob_r, exp, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] y, held;
    for (int x = 0; x < 256; x++) begin
      y = ref_inv(8'(x));
      y = y ^ rotl(y, 1) ^ rotl(y, 2) ^ rotl(y, 3) ^ rotl(y, 4) ^ 8'h63;
      fwd_ref[x] = y;
      inv_ref[y] = 8'(x);
    end

    repeat (3) @(posedge clk);
    #1;
    check({7'd0, ov_r}, 8'h00, "R7 reset valid");
    check(ob_r, 8'h00, "R7 reset data");
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < 10; i++)
      step(1'b1, VECS[i][16], VECS[i][15:8], VECS[i][7:0], "R4 known vector");

    for (int x = 0; x < 256; x++)
      step(1'b1, 1'b0, 8'(x), fwd_ref[x], "R1 forward sweep");
    for (int x = 0; x < 256; x++)
      step(1'b1, 1'b1, 8'(x), inv_ref[x], "R2 inverse sweep");

    // R3: round trip through the design itself
    for (int x = 0; x < 256; x += 7) begin
      step(1'b1, 1'b0, 8'(x), fwd_ref[x], "R3 forward leg");
      y = ob_c;
      step(1'b1, 1'b1, y, 8'(x), "R3 return leg");
    end

    // R9: alternating modes back to back
    for (int x = 3; x < 40; x++)
      step(1'b1, x[0], 8'(x * 11), x[0] ? inv_ref[8'(x * 11)] : fwd_ref[8'(x * 11)],
           "R9 alternating mode");

    // R6: idle cycles keep the registered byte
    step(1'b1, 1'b0, 8'h53, 8'hED, "R6 load");
    held = ob_r;
    @(negedge clk); in_valid = 1'b0; in_byte = 8'h01; in_inv = 1'b1;
    #1; check({7'd0, ov_c}, 8'h00, "R8 comb idle valid");
    @(posedge clk); #1;
    check({7'd0, ov_r}, 8'h00, "R6 idle valid");
    check(ob_r, held, "R6 idle hold");
    @(posedge clk); #1;
    check(ob_r, held, "R6 second idle hold");

    // R7: reset in mid-stream
    step(1'b1, 1'b0, 8'hFF, 8'h16, "R7 preload");
    @(negedge clk); rst = 1'b1; in_valid = 1'b1; in_byte = 8'h10;
    @(posedge clk); #1;
    check({7'd0, ov_r}, 8'h00, "R7 mid reset valid");
    check(ob_r, 8'h00, "R7 mid reset data");
    @(negedge clk); rst = 1'b0; in_valid = 1'b0;
    step(1'b1, 1'b1, 8'h00, 8'h52, "R4 after reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule